// File: doc/BRIEF.md
# ALU with Stored Condition Flags

This block is the arithmetic unit of a single-cycle load/store processor datapath, extended with a four-bit condition register. Each cycle it combines two operands under a three-bit operation code and presents the result together with a live zero indication. The branch logic consumes the zero indication, and the result goes to the data memory address or to the register write port.

Carry, overflow, zero and negative are kept in a small register. That register is loaded only in a cycle in which the control decoder marks the instruction as a register-to-register arithmetic or logic operation. A separate read-flags select replaces the write-back value with the stored flags, zero-extended. This gives a "move flags to register" instruction whose destination is the Rd field (instruction bits 15..11), selected outside this block. The value read is always the one left by the latest earlier register-to-register operation, never by the current cycle.

Top module: `alu_cc_top`

## Requirements
- R1: `alu_op` 0 gives A+B, 1 gives A-B, and 6 gives 1 when A is less than B as signed numbers, else 0. All results are modulo 2^WIDTH.
- R2: `alu_op` 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 gives NOT(A OR B), and 7 passes B through.
- R3: `zero` is 1 in the same cycle exactly when all bits of `result` are 0.
- R4: The carry flag is the carry-out of the top bit of A+B for code 0, and of A+~B+1 for codes 1 and 6. It is 0 for the logic codes.
- R5: The overflow flag is set when the two adder inputs (A, and B inverted for codes 1 and 6) share a sign and the adder sum's sign differs from it. It is 0 for the logic codes.
- R6: The stored zero flag is the `zero` value of the capturing cycle, and the stored negative flag is that cycle's `result` top bit.
- R7: With `rtype_upd`=1 and `flags_rd`=0, the flags load at that cycle's rising edge and are readable in the next cycle.
- R8: With `rtype_upd`=0, the stored flags do not change, whatever the operands and code.
- R9: With `flags_rd`=1, `wb_data` bit 3 is carry, bit 2 overflow, bit 1 zero, bit 0 negative, and all higher bits are 0.
- R10: With `flags_rd`=0, `wb_data` equals `result`.
- R11: A synchronous reset (`rst`=1 at a rising edge) clears all four stored flags.
- R12: When `flags_rd`=1 and `rtype_upd`=1 coincide, `wb_data` returns the previously stored flags and no load takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| alu_op | input | 3 | Operation code |
| rtype_upd | input | 1 | Register-to-register instruction strobe; allows a flag load |
| flags_rd | input | 1 | Selects stored flags onto the write-back value |
| result | output | WIDTH | Operation result |
| zero | output | 1 | Live all-zero indication of `result` |
| wb_data | output | WIDTH | Value for the register file write port |

## Verification
The update strobe and the flag read can be asserted in the same cycle. The read must then see the older flags, and the load must be suppressed. In every sweep step, the cycle that reads the flags raises `rtype_upd` on alternate steps and drives different operands, and the read value is compared with the flags expected from the previous step. A directed sequence then reads the flags again one cycle later, to confirm that the coincident cycle left them unchanged.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
   localparam int OP_BITS = 3;
   localparam int CC_BITS = 4;

   typedef enum logic [OP_BITS-1:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_NOR  = 3'd5,
      OP_SLT  = 3'd6,
      OP_PASS = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic c;
      logic v;
      logic z;
      logic n;
   } cc_t;
endpackage

// File: rtl/alu_cc_core.sv
module alu_cc_core
   import alu_cc_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int ZCHUNK = 8
) (
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic [OP_BITS-1:0] op,
   output logic [WIDTH-1:0]   res,
   output cc_t                cc
);
   localparam int NCHUNK = (ZCHUNK > 0 && ZCHUNK < WIDTH) ? WIDTH / ZCHUNK : 1;

   logic             inv_b;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   sum_ext;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;
   logic             arith;
   logic             zflag;

   always_comb begin
      inv_b   = (op == OP_SUB) || (op == OP_SLT);
      b_eff   = inv_b ? ~b : b;
      sum_ext = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, inv_b};
      sum     = sum_ext[WIDTH-1:0];
      cout    = sum_ext[WIDTH];
      ovf     = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
      arith   = (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
   end

   always_comb begin
      unique case (alu_op_e'(op))
         OP_ADD, OP_SUB: res = sum;
         OP_AND:         res = a & b;
         OP_OR:          res = a | b;
         OP_XOR:         res = a ^ b;
         OP_NOR:         res = ~(a | b);
         OP_SLT:         res = {{(WIDTH-1){1'b0}}, sum[WIDTH-1] ^ ovf};
         OP_PASS:        res = b;
         default:        res = '0;
      endcase
   end

   generate
      if (NCHUNK == 1) begin : g_zero_flat
         assign zflag = ~|res;
      end else begin : g_zero_split
         logic [NCHUNK-1:0] part;
         for (genvar g = 0; g < NCHUNK; g++) begin : g_part
            assign part[g] = |res[g*ZCHUNK +: ZCHUNK];
         end
         assign zflag = ~|part;
      end
   endgenerate

   always_comb begin
      cc.c = arith & cout;
      cc.v = arith & ovf;
      cc.z = zflag;
      cc.n = res[WIDTH-1];
   end
endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
   import alu_cc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  cc_t  d,
   output cc_t  q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/alu_cc_wbsel.sv
module alu_cc_wbsel
   import alu_cc_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             sel_cc,
   input  logic [WIDTH-1:0] res,
   input  cc_t              cc_q,
   output logic [WIDTH-1:0] wb
);
   always_comb begin
      if (sel_cc) wb = {{(WIDTH-CC_BITS){1'b0}}, cc_q};
      else        wb = res;
   end
endmodule

// File: rtl/alu_cc_top.sv
module alu_cc_top
   import alu_cc_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int ZCHUNK = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   input  logic [OP_BITS-1:0] alu_op,
   input  logic               rtype_upd,
   input  logic               flags_rd,
   output logic [WIDTH-1:0]   result,
   output logic               zero,
   output logic [WIDTH-1:0]   wb_data
);
   generate
      if (WIDTH <= CC_BITS) begin : g_chk_width
         $error("alu_cc_top: WIDTH must exceed the flag count");
      end
      if (ZCHUNK > 0 && ZCHUNK < WIDTH && (WIDTH % ZCHUNK) != 0) begin : g_chk_chunk
         $error("alu_cc_top: ZCHUNK must divide WIDTH");
      end
   endgenerate

   cc_t  cc_now;
   cc_t  cc_q;
   logic cc_load;

   assign cc_load = rtype_upd & ~flags_rd;

   alu_cc_core #(.WIDTH(WIDTH), .ZCHUNK(ZCHUNK)) core_i (
      .a   (op_a),
      .b   (op_b),
      .op  (alu_op),
      .res (result),
      .cc  (cc_now)
   );

   assign zero = cc_now.z;

   alu_cc_flagreg flag_i (
      .clk  (clk),
      .rst  (rst),
      .load (cc_load),
      .d    (cc_now),
      .q    (cc_q)
   );

   alu_cc_wbsel #(.WIDTH(WIDTH)) wb_i (
      .sel_cc (flags_rd),
      .res    (result),
      .cc_q   (cc_q),
      .wb     (wb_data)
   );
endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker
   import alu_cc_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             rtype_upd,
   input logic             flags_rd,
   input logic [WIDTH-1:0] result,
   input logic [WIDTH-1:0] wb_data,
   input cc_t              cc_now,
   input cc_t              cc_q
);
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
      flags_rd |-> (wb_data[WIDTH-1:CC_BITS] == '0));

   a_r10_wb_pass: assert property (@(posedge clk) disable iff (rst)
      !flags_rd |-> (wb_data == result));

   a_r7_capture: assert property (@(posedge clk) disable iff (rst)
      (rtype_upd && !flags_rd) |=> (cc_q == $past(cc_now)));

   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !rtype_upd |=> $stable(cc_q));

   a_r12_read_blocks_load: assert property (@(posedge clk) disable iff (rst)
      (rtype_upd && flags_rd) |=> $stable(cc_q));

   a_r11_reset_clear: assert property (@(posedge clk)
      rst |=> (cc_q == '0));
endmodule

bind alu_cc_top alu_cc_checker #(.WIDTH(WIDTH)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .rtype_upd (rtype_upd),
   .flags_rd  (flags_rd),
   .result    (result),
   .wb_data   (wb_data),
   .cc_now    (cc_now),
   .cc_q      (cc_q)
);

// File: tb/alu_cc_top_tb_top.sv
module alu_cc_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TW   = 8;
   localparam int MASK = (1 << TW) - 1;
   localparam int SGN  = 1 << (TW - 1);

   logic          clk = 1'b0;
   logic          rst;
   logic [TW-1:0] op_a, op_b;
   logic [2:0]    alu_op;
   logic          rtype_upd, flags_rd;
   logic [TW-1:0] result, wb_data;
   logic          zero;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_cc_top #(.WIDTH(TW), .ZCHUNK(2)) dut_i (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .alu_op(alu_op),
      .rtype_upd(rtype_upd), .flags_rd(flags_rd),
      .result(result), .zero(zero), .wb_data(wb_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int pick(input int i, input int salt);
      case (i)
         16: return 127;
         17: return 128;
         18: return 255;
         19: return 1;
         default: return (i * 17 + salt) & MASK;
      endcase
   endfunction

   // Returns {C,V,Z,N} in bits 3..0; result through r.
   function automatic int model(input int a, input int b, input int op, output int r);
      int s, c, v, be, ar;
      ar = (op == 0 || op == 1 || op == 6);
      be = (op == 1 || op == 6) ? (~b & MASK) : b;
      s  = a + be + ((op == 1 || op == 6) ? 1 : 0);
      c  = (s >> TW) & 1;
      s  = s & MASK;
      v  = (((a & SGN) == (be & SGN)) && ((s & SGN) != (a & SGN))) ? 1 : 0;
      case (op)
         0, 1: r = s;
         2: r = a & b;
         3: r = a | b;
         4: r = a ^ b;
         5: r = ~(a | b) & MASK;
         6: r = (((a & SGN) ? a - 256 : a) < ((b & SGN) ? b - 256 : b)) ? 1 : 0;
         default: r = b;
      endcase
      if (!ar) begin c = 0; v = 0; end
      return (c << 3) | (v << 2) | ((r == 0 ? 1 : 0) << 1) | ((r >> (TW-1)) & 1);
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int r, f, prev;
      rst = 1'b1; op_a = '0; op_b = '0; alu_op = '0; rtype_upd = 1'b0; flags_rd = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1 chk("R11 reset flags", wb_data, 0);

      // Sweep: compute and capture, then read with coincident strobe
      for (int ia = 0; ia < 20; ia++) begin
         for (int ib = 0; ib < 20; ib++) begin
            for (int op = 0; op < 8; op++) begin
               int a, b;
               a = pick(ia, 0);
               b = pick(ib, 3) ^ 8'h5a;
               f = model(a, b, op, r);
               @(negedge clk);
               op_a = a[TW-1:0]; op_b = b[TW-1:0]; alu_op = op[2:0];
               rtype_upd = 1'b1; flags_rd = 1'b0;
               #1;
               chk((op == 0 || op == 1 || op == 6) ? "R1 result" : "R2 result", result, r);
               chk("R3 zero", zero, (r == 0) ? 1 : 0);
               chk("R10 wb pass", wb_data, r);
               @(negedge clk);
               op_a = ~a[TW-1:0]; op_b = a[TW-1:0]; alu_op = 3'd1;
               flags_rd = 1'b1; rtype_upd = ((ia + ib + op) & 1) ? 1'b1 : 1'b0;
               #1;
               // R4 R5 R6 R7 R9 R12: stored flags from the previous cycle
               chk("R7/R9 flags read", wb_data, f);
            end
         end
      end

      // Directed R12 and R8 sequence
      @(negedge clk);
      op_a = 8'h00; op_b = 8'h00; alu_op = 3'd0; rtype_upd = 1'b1; flags_rd = 1'b0;
      @(negedge clk);
      op_a = 8'hff; op_b = 8'h01; alu_op = 3'd0; rtype_upd = 1'b1; flags_rd = 1'b1;
      #1 chk("R12 coincident read old", wb_data, 4'b0010);
      @(negedge clk);
      rtype_upd = 1'b0; flags_rd = 1'b1;
      #1 chk("R12 no load on coincident", wb_data, 4'b0010);
      @(negedge clk);
      op_a = 8'h7f; op_b = 8'h01; alu_op = 3'd0; rtype_upd = 1'b0; flags_rd = 1'b0;
      #1 chk("R1 add overflow result", result, 8'h80);
      @(negedge clk);
      flags_rd = 1'b1;
      #1 chk("R8 no load without strobe", wb_data, 4'b0010);
      @(negedge clk);
      op_a = 8'h7f; op_b = 8'h01; alu_op = 3'd0; rtype_upd = 1'b1; flags_rd = 1'b0;
      @(negedge clk);
      rtype_upd = 1'b0; flags_rd = 1'b1;
      #1 chk("R5 add overflow flags", wb_data, 4'b0101);
      @(negedge clk);
      op_a = 8'h00; op_b = 8'h01; alu_op = 3'd1; rtype_upd = 1'b1; flags_rd = 1'b0;
      @(negedge clk);
      rtype_upd = 1'b0; flags_rd = 1'b1;
      #1 chk("R4 sub borrow clears carry", wb_data, 4'b0001);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; flags_rd = 1'b1;
      #1 chk("R11 mid-run reset", wb_data, 0);
      prev = 0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule